// File: doc/BRIEF.md
# ECC Error Status Capture Register

This block sits inside a memory controller and keeps a record of the first memory error that matters. An ECC checker feeds it events: single-bit error, multi-bit error and parity error, together with the failing physical address, the current check mode, a memory-width flag and the syndrome. The block folds these into one 64-bit status word that software reads.

Capture follows a sticky priority. A single-bit error locks out later single-bit errors. A multi-bit error locks out everything. A multi-bit error that arrives while only a single-bit record is held replaces that record.

Software clears the two sticky flags through a plain register write port. Once both flags are clear, capture is armed again. If an error arrives in the same cycle as a clearing write, the error wins.

Top module: `ecc_err_status`

## Requirements
- R1: Status word layout: address in bits 63:28, mode in bits 26:24, width flag in bit 21, syndrome in bits 15:8, multi-bit flag in bit 1, single-bit flag in bit 0.
- R2: After a synchronous reset, both flags read 0. The other fields have no guaranteed value.
- R3: With both flags clear, a single-bit error captures the address, mode, width flag and syndrome, and sets the single-bit flag one cycle later. The width flag is copied as given: 0 means a 64-bit memory and 1 means a 32-bit memory.
- R4: With the multi-bit flag clear, a multi-bit error captures all fields and sets the multi-bit flag. A parity error has the same effect only while the mode input equals the parity code 3'b010; in any other mode it is ignored.
- R5: While the multi-bit flag is set, no field changes and the flag stays set, whatever errors arrive, unless a write clears it.
- R6: While only the single-bit flag is set, a further single-bit error changes no field.
- R7: While only the single-bit flag is set, a multi-bit error overwrites every captured field and sets the multi-bit flag, and the single-bit flag stays set.
- R8: A write with bit 0 at 0 clears the single-bit flag, and a write with bit 1 at 0 clears the multi-bit flag. Writing 1 to a flag bit leaves it unchanged. With both flags clear, the next error is captured.
- R9: When an error arrives in the same cycle as a write that clears the lock, the error is captured and its flag ends up set.
- R10: When single-bit and multi-bit errors arrive together while the block is idle, the event is treated as multi-bit: the multi-bit flag sets and the single-bit flag stays 0.
- R11: Reserved bits always read 0. Writes have no effect on reserved bits or on the captured fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_sbe_i | input | 1 | Single-bit error event |
| err_mbe_i | input | 1 | Multi-bit error event |
| err_par_i | input | 1 | Parity error event |
| err_addr_i | input | 36 | Physical address of the failing access |
| err_mode_i | input | 3 | Active check mode (3'b010 = parity) |
| err_mem32_i | input | 1 | Memory width flag, 1 = 32-bit |
| err_synd_i | input | 8 | Syndrome of the failing access |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | 64 | Write data; only bits 1 and 0 act |
| status_o | output | 64 | Status word |

## Verification
The bench builds the block with the default parameters: a 36-bit address, a 3-bit mode, an 8-bit syndrome and parity code 3'b010. With these values the fixed 64-bit layout is fully populated, so every field edge and every reserved gap can be seen at the port. The random phase sends dense error bursts, mixing in writes that clear the flags. This drives the block through every lock state, including the single-bit record being replaced by a multi-bit error and clearing writes that land in the same cycle as an error. Parity events are sent in both parity and non-parity modes, so the mode gate is exercised both ways.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;

    parameter int STAT_W  = 64;
    parameter int ADDR_W  = 36;
    parameter int MODE_W  = 3;
    parameter int SYND_W  = 8;

    localparam int ADDR_LSB  = STAT_W - ADDR_W;
    localparam int MODE_LSB  = 24;
    localparam int WIDTH_BIT = 21;
    localparam int SYND_LSB  = 8;
    localparam int MB_BIT    = 1;
    localparam int SB_BIT    = 0;

    localparam logic [MODE_W-1:0] PARITY_CODE = 3'b010;

    typedef enum logic [1:0] {
        EVT_NONE   = 2'd0,
        EVT_SINGLE = 2'd1,
        EVT_MULTI  = 2'd2
    } evt_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [MODE_W-1:0] mode;
        logic              mem32;
        logic [SYND_W-1:0] synd;
    } capture_t;

    function automatic logic [STAT_W-1:0] pack_status(
        input capture_t c,
        input logic     mb,
        input logic     sb
    );
        logic [STAT_W-1:0] w;
        w = '0;
        w[ADDR_LSB +: ADDR_W] = c.addr;
        w[MODE_LSB +: MODE_W] = c.mode;
        w[WIDTH_BIT]          = c.mem32;
        w[SYND_LSB +: SYND_W] = c.synd;
        w[MB_BIT]             = mb;
        w[SB_BIT]             = sb;
        return w;
    endfunction

endpackage

// File: rtl/ecc_evt_classify.sv
module ecc_evt_classify
    import ecc_stat_pkg::*;
#(
    parameter logic [MODE_W-1:0] PAR_CODE = PARITY_CODE
) (
    input  logic              sbe,
    input  logic              mbe,
    input  logic              par,
    input  logic [MODE_W-1:0] mode,
    output evt_kind_e         kind
);

    logic par_hit;

    always_comb begin
        par_hit = par && (mode == PAR_CODE);
        if (mbe || par_hit)
            kind = EVT_MULTI;
        else if (sbe)
            kind = EVT_SINGLE;
        else
            kind = EVT_NONE;
    end

endmodule

// File: rtl/ecc_stat_lock.sv
module ecc_stat_lock
    import ecc_stat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  evt_kind_e kind,
    input  logic      clr_sb,
    input  logic      clr_mb,
    output logic      sb_q,
    output logic      mb_q,
    output logic      cap_en
);

    logic eff_sb, eff_mb;
    logic take_multi, take_single;

    always_comb begin
        eff_sb      = sb_q && !clr_sb;
        eff_mb      = mb_q && !clr_mb;
        take_multi  = (kind == EVT_MULTI)  && !eff_mb;
        take_single = (kind == EVT_SINGLE) && !eff_mb && !eff_sb;
        cap_en      = take_multi || take_single;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sb_q <= 1'b0;
            mb_q <= 1'b0;
        end else begin
            sb_q <= eff_sb || take_single;
            mb_q <= eff_mb || take_multi;
        end
    end

    // R5: a held multi-bit flag survives everything except its own clear
    a_r5_mb_sticky: assert property (@(posedge clk) disable iff (rst)
        mb_q && !clr_mb |=> mb_q);

    // R4: a multi-bit class event always leaves the multi-bit flag set
    a_r4_multi_sets: assert property (@(posedge clk) disable iff (rst)
        kind == EVT_MULTI |=> mb_q);

    // R8: a clear with no event leaves the flag low
    a_r8_sb_clear: assert property (@(posedge clk) disable iff (rst)
        clr_sb && kind == EVT_NONE |=> !sb_q);

    // R10: an idle multi event never raises the single-bit flag
    a_r10_multi_no_sb: assert property (@(posedge clk) disable iff (rst)
        !sb_q && kind == EVT_MULTI |=> !sb_q);

endmodule

// File: rtl/ecc_stat_fields.sv
module ecc_stat_fields
    import ecc_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cap_en,
    input  capture_t cap_d,
    output capture_t cap_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cap_q <= '0;
        else if (cap_en)
            cap_q <= cap_d;
    end

endmodule

// File: rtl/ecc_err_status.sv
module ecc_err_status
    import ecc_stat_pkg::*;
#(
    parameter logic [MODE_W-1:0] PAR_CODE = PARITY_CODE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err_sbe_i,
    input  logic              err_mbe_i,
    input  logic              err_par_i,
    input  logic [ADDR_W-1:0] err_addr_i,
    input  logic [MODE_W-1:0] err_mode_i,
    input  logic              err_mem32_i,
    input  logic [SYND_W-1:0] err_synd_i,
    input  logic              wr_en_i,
    input  logic [STAT_W-1:0] wr_data_i,
    output logic [STAT_W-1:0] status_o
);

    evt_kind_e kind;
    logic      clr_sb, clr_mb;
    logic      sb_q, mb_q, cap_en;
    capture_t  cap_d, cap_q;

    assign clr_sb = wr_en_i && !wr_data_i[SB_BIT];
    assign clr_mb = wr_en_i && !wr_data_i[MB_BIT];

    always_comb begin
        cap_d.addr  = err_addr_i;
        cap_d.mode  = err_mode_i;
        cap_d.mem32 = err_mem32_i;
        cap_d.synd  = err_synd_i;
    end

    ecc_evt_classify #(.PAR_CODE(PAR_CODE)) u_cls (
        .sbe  (err_sbe_i),
        .mbe  (err_mbe_i),
        .par  (err_par_i),
        .mode (err_mode_i),
        .kind (kind)
    );

    ecc_stat_lock u_lock (
        .clk    (clk),
        .rst    (rst),
        .kind   (kind),
        .clr_sb (clr_sb),
        .clr_mb (clr_mb),
        .sb_q   (sb_q),
        .mb_q   (mb_q),
        .cap_en (cap_en)
    );

    ecc_stat_fields u_fld (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .cap_d  (cap_d),
        .cap_q  (cap_q)
    );

    assign status_o = pack_status(cap_q, mb_q, sb_q);

    // R5: fields frozen while the multi-bit flag is held
    a_r5_fields_frozen: assert property (@(posedge clk) disable iff (rst)
        mb_q && !clr_mb |=> $stable(status_o[STAT_W-1:SYND_LSB]));

    // R6: single-bit lock ignores further single-bit errors
    a_r6_sb_lock: assert property (@(posedge clk) disable iff (rst)
        sb_q && !mb_q && !clr_sb && !err_mbe_i && !err_par_i
        |=> $stable(status_o[STAT_W-1:SYND_LSB]));

    // R7: multi-bit overrides a single-bit record
    a_r7_override: assert property (@(posedge clk) disable iff (rst)
        sb_q && !mb_q && err_mbe_i && !clr_sb
        |=> status_o[MB_BIT] && status_o[SB_BIT]
            && status_o[ADDR_LSB +: ADDR_W] == $past(err_addr_i));

    // R9: error wins over a same-cycle clear
    a_r9_error_wins: assert property (@(posedge clk) disable iff (rst)
        err_sbe_i && !err_mbe_i && !err_par_i && clr_sb && clr_mb
        |=> status_o[SB_BIT]);

endmodule

// File: tb/ecc_err_status_tb_top.sv
module ecc_err_status_tb_top;
    import ecc_stat_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              sbe, mbe, par, m32, wen;
    logic [ADDR_W-1:0] addr;
    logic [MODE_W-1:0] mode;
    logic [SYND_W-1:0] synd;
    logic [STAT_W-1:0] wdata;
    logic [STAT_W-1:0] status;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic     e_sb, e_mb, e_valid;
    capture_t e_cap;

    always #2 clk = ~clk;

    ecc_err_status dut_i (
        .clk(clk), .rst(rst),
        .err_sbe_i(sbe), .err_mbe_i(mbe), .err_par_i(par),
        .err_addr_i(addr), .err_mode_i(mode), .err_mem32_i(m32),
        .err_synd_i(synd), .wr_en_i(wen), .wr_data_i(wdata),
        .status_o(status)
    );

    function automatic logic [STAT_W-1:0] exp_word(input capture_t c, input logic mb, input logic sb);
        logic [STAT_W-1:0] w;
        w = '0;
        w[63:28] = c.addr;
        w[26:24] = c.mode;
        w[21]    = c.mem32;
        w[15:8]  = c.synd;
        w[1]     = mb;
        w[0]     = sb;
        return w;
    endfunction

    task automatic check(input string req, input logic [STAT_W-1:0] got, input logic [STAT_W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // reference model from the requirements
    task automatic model_step();
        logic eff_sb, eff_mb, multi, single;
        eff_sb = e_sb && !(wen && !wdata[0]);
        eff_mb = e_mb && !(wen && !wdata[1]);
        multi  = mbe || (par && mode == 3'b010);
        single = sbe && !multi;
        if (multi && !eff_mb) begin
            e_cap = '{addr, mode, m32, synd}; e_valid = 1; e_mb = 1; e_sb = eff_sb;
        end else if (single && !eff_mb && !eff_sb) begin
            e_cap = '{addr, mode, m32, synd}; e_valid = 1; e_sb = 1; e_mb = eff_mb;
        end else begin
            e_sb = eff_sb; e_mb = eff_mb;
        end
    endtask

    task automatic drive(input logic s, input logic m, input logic p,
                         input logic [ADDR_W-1:0] a, input logic [MODE_W-1:0] md,
                         input logic w32, input logic [SYND_W-1:0] sy,
                         input logic we, input logic [STAT_W-1:0] wd);
        sbe = s; mbe = m; par = p; addr = a; mode = md; m32 = w32; synd = sy;
        wen = we; wdata = wd;
        model_step();
        @(negedge clk);
        sbe = 0; mbe = 0; par = 0; wen = 0;
    endtask

    task automatic cmp(input string req);
        logic [STAT_W-1:0] mask;
        mask = e_valid ? '1 : 64'h3;
        check(req, status & mask, exp_word(e_cap, e_mb, e_sb) & mask);
    endtask

    task automatic idle(); drive(0,0,0,'0,'0,0,'0,0,'0); endtask
    task automatic clr_all(); drive(0,0,0,'0,'0,0,'0,1,64'h0); endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        sbe = 0; mbe = 0; par = 0; m32 = 0; wen = 0;
        addr = '0; mode = '0; synd = '0; wdata = '0;
        e_sb = 0; e_mb = 0; e_valid = 0; e_cap = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R2 reset flags", status[1:0], 2'b00);
        cmp("R11 reserved after reset");

        // R3 single-bit capture, 64-bit width
        drive(1,0,0,36'h9_1234_5678,3'b001,0,8'hA5,0,'0);
        cmp("R3 single capture");
        check("R1 layout addr", status[63:28], 36'h9_1234_5678);
        check("R1 layout synd", status[15:8], 8'hA5);
        // R6 further single ignored
        drive(1,0,0,36'h1_1111_1111,3'b001,1,8'h11,0,'0);
        cmp("R6 single lock");
        // R11 write to fields ignored, flags written 1 no change (R8)
        drive(0,0,0,'0,'0,0,'0,1,64'hFFFF_FFFF_FFFF_FFFF);
        cmp("R11 R8 write ones");
        // R7 multi overrides single
        drive(0,1,0,36'hF_0000_0001,3'b011,1,8'h3C,0,'0);
        cmp("R7 override");
        check("R3 width flag 32-bit", status[21], 1'b1);
        // R5 frozen
        drive(1,1,1,36'h2_2222_2222,3'b010,0,8'h22,0,'0);
        cmp("R5 multi freeze");
        // R8 clear only sb keeps mb
        drive(0,0,0,'0,'0,0,'0,1,64'h2);
        cmp("R8 clear sb only");
        drive(0,1,0,36'h3_3333_3333,3'b001,0,8'h33,0,'0);
        cmp("R5 still frozen");
        clr_all();
        cmp("R8 both clear");
        // R4 parity in non-parity mode ignored
        drive(0,0,1,36'h4_4444_4444,3'b001,0,8'h44,0,'0);
        cmp("R4 parity ignored");
        // R4 parity in parity mode
        drive(0,0,1,36'h5_5555_5555,3'b010,1,8'h55,0,'0);
        cmp("R4 parity capture");
        // R9 error with clear
        drive(1,0,0,36'h6_6666_6666,3'b001,0,8'h66,1,64'h0);
        cmp("R9 error wins");
        clr_all();
        // R10 simultaneous
        drive(1,1,0,36'h7_7777_7777,3'b001,0,8'h77,0,'0);
        cmp("R10 simultaneous");
        check("R10 sb stays low", status[0], 1'b0);
        clr_all();
        cmp("R8 rearm");

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            drive(r[0] & r[1], r[2] & r[3] & r[4], r[5] & r[6],
                  {$urandom, r[11:8]}, r[14:12], r[15], r[23:16],
                  r[24] & r[25] & r[26], {$urandom, 30'h0, r[28:27]});
            cmp("R5 R6 R7 R8 R9 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule